// File: doc/BRIEF.md
# Two-Channel Shadowed PWM Peripheral

This block is a pulse-width modulator with two output channels, controlled through a plain 32-bit register read/write port. Every channel has four registers: control, prescaler, period and duty. A write does not reach the waveform logic at once. It lands in a staging copy and raises an "update pending" flag for that field. The flag drops when the staged value has been copied into the working copy that drives the counters. Software writes a field and then polls the shared status word until that field's flag clears.

Each channel divides the input clock by a programmable prescaler and runs a period counter on the divided tick. It compares that counter with the duty value, applies an optional output inversion, and is gated by an enable. Prescaler, period and duty can be staged in two ways. In autoload mode they are copied in at a period boundary, so every period is built from one consistent set of values. In manual mode they are copied in on explicit load bits. Disabling a channel either finishes the current period or stops on the next clock, as software chooses.

Top module: `pwm_shadow_top`

## Requirements
- R1: After reset, every register reads zero, the status word reads zero, and both outputs are low.
- R2: Channel n owns byte addresses 16n+0 (control), 16n+4 (prescaler), 16n+8 (period) and 16n+12 (duty). A read returns the most recently written value, masked to its field width: control 6 bits, prescaler 10, period 12, duty 12. The address space holds four channel slots. Slots 2 and 3 read zero and ignore writes. The status word at 0x40 ignores writes. Any other address reads zero. The control bits are: bit 0 enable, bit 1 invert, bit 2 autoload, bit 3 stop-now, bit 4 load prescaler, bit 5 load period.
- R3: A register write sets that field's pending bit at status bit 4n+k on the same clock edge. k is 0 for control, 1 for prescaler, 2 for period and 3 for duty.
- R4: A control write takes effect on the next clock edge, and its pending bit clears on that edge.
- R5: While the working control has autoload set, staged prescaler, period and duty values are copied in on the edge where the period counter wraps, or on any edge while the channel is stopped. Their pending bits clear on that edge. A write on the copy edge keeps its bit pending.
- R6: While the working control has autoload clear, a staged prescaler is copied in only while load-prescaler is set, and a staged period only while load-period is set. A staged duty is copied in on the next edge. Without the copy condition, the pending bit stays set.
- R7: A running channel advances its period counter once every prescaler+1 clocks. One period lasts (period+1)·(prescaler+1) clocks. The counter starts at 0 on the second edge after the control write that sets enable.
- R8: While running, the output before inversion is high exactly when the period counter is below duty. Duty 0 gives a constant low. Duty greater than period gives a constant high.
- R9: The invert bit flips the output, both while running and while idle.
- R10: If a working control has enable clear and stop-now set, a running channel stops on the next edge. The output is at its idle level from the second edge after the control write.
- R11: If a working control has enable clear and stop-now clear, the channel keeps running until the end of the current period and then stops.
- R12: A stopped channel drives its idle level, which is the invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 2 | Channel outputs |

## Verification
A write is sampled on one rising edge, so its pending bit is visible at the falling edge that follows. A control value becomes active one edge later. A load-bit copy lands two edges after the control write that set the load bit, and a stop-now or enable change reaches the pin two edges after the write. The bench waits exactly those edges and then samples at the falling edge. Waveform checks start at cycle 0 on the second edge after enable. Each sample is compared with a bench function of cycle index, prescaler, period, duty and invert. Where the write phase against the period is not pinned, the checks count high cycles over a full-period window, so the result does not depend on that phase.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int CTRL_W = 6;
  localparam int PRE_W  = 10;
  localparam int PER_W  = 12;
  localparam int N_REG  = 4;

  typedef struct packed {
    logic load_per;
    logic load_pre;
    logic stop_now;
    logic autoload;
    logic invert;
    logic enable;
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PRE  = 2'd1,
    REG_PER  = 2'd2,
    REG_DUTY = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_shadow_field.sv
module pwm_shadow_field #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         xfer_i,
  output logic [W-1:0] sh_o,
  output logic [W-1:0] act_o,
  output logic         pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_o   <= '0;
      act_o  <= '0;
      pend_o <= 1'b0;
    end else if (wr_i) begin
      sh_o   <= wdata_i;
      pend_o <= 1'b1;
    end else if (pend_o && xfer_i) begin
      act_o  <= sh_o;
      pend_o <= 1'b0;
    end
  end

  a_r3_write_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pend_o);
  a_r5_xfer_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && xfer_i && !wr_i) |=> (!pend_o && act_o == $past(sh_o)));
  a_r6_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !xfer_i) |=> pend_o);
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REG-1:0]  wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              boundary_i,
  output ctrl_t             sh_ctrl_o,
  output ctrl_t             act_ctrl_o,
  output logic [PRE_W-1:0]  sh_pre_o,
  output logic [PRE_W-1:0]  act_pre_o,
  output logic [PER_W-1:0]  sh_per_o,
  output logic [PER_W-1:0]  act_per_o,
  output logic [PER_W-1:0]  sh_duty_o,
  output logic [PER_W-1:0]  act_duty_o,
  output logic [N_REG-1:0]  pend_o
);
  logic [CTRL_W-1:0] sh_c, act_c;
  logic              at_bound, xfer_pre, xfer_per, xfer_duty;

  assign sh_ctrl_o  = ctrl_t'(sh_c);
  assign act_ctrl_o = ctrl_t'(act_c);

  assign at_bound  = act_ctrl_o.autoload && boundary_i;
  assign xfer_pre  = at_bound || (!act_ctrl_o.autoload && act_ctrl_o.load_pre);
  assign xfer_per  = at_bound || (!act_ctrl_o.autoload && act_ctrl_o.load_per);
  assign xfer_duty = at_bound || !act_ctrl_o.autoload;

  pwm_shadow_field #(.W(CTRL_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i[REG_CTRL]),
    .wdata_i(wdata_i[CTRL_W-1:0]), .xfer_i(1'b1),
    .sh_o(sh_c), .act_o(act_c), .pend_o(pend_o[REG_CTRL]));

  pwm_shadow_field #(.W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i[REG_PRE]),
    .wdata_i(wdata_i[PRE_W-1:0]), .xfer_i(xfer_pre),
    .sh_o(sh_pre_o), .act_o(act_pre_o), .pend_o(pend_o[REG_PRE]));

  pwm_shadow_field #(.W(PER_W)) u_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i[REG_PER]),
    .wdata_i(wdata_i[PER_W-1:0]), .xfer_i(xfer_per),
    .sh_o(sh_per_o), .act_o(act_per_o), .pend_o(pend_o[REG_PER]));

  pwm_shadow_field #(.W(PER_W)) u_duty (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i[REG_DUTY]),
    .wdata_i(wdata_i[PER_W-1:0]), .xfer_i(xfer_duty),
    .sh_o(sh_duty_o), .act_o(act_duty_o), .pend_o(pend_o[REG_DUTY]));

  // R4: a control write is accepted on the following edge
  a_r4_ctrl_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o[REG_CTRL] && !wr_i[REG_CTRL]) |=> (!pend_o[REG_CTRL] && act_c == $past(sh_c)));
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_shadow_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             boundary_o
);
  logic             running_q;
  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] cnt_q;
  logic             tick, wrap;

  assign tick = running_q && (pre_q >= pre_i);
  // >= so a period shrunk mid-flight still wraps
  assign wrap = tick && (cnt_q >= per_i);
  assign boundary_o = !running_q || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
    end else if (!running_q) begin
      running_q <= ctrl_i.enable;
      pre_q     <= '0;
      cnt_q     <= '0;
    end else if (!ctrl_i.enable && (ctrl_i.stop_now || wrap)) begin
      running_q <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign pwm_o = running_q ? ((cnt_q < duty_i) ^ ctrl_i.invert) : ctrl_i.invert;

  a_r10_stop_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !ctrl_i.enable && ctrl_i.stop_now) |=> !running_q);
  a_r11_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !ctrl_i.enable && !ctrl_i.stop_now && !wrap) |=> running_q);
  a_r8_duty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && duty_i == '0) |-> (pwm_o == ctrl_i.invert));
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
  import pwm_shadow_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int N_SLOT = 4,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam int STAT_W = N_REG * N_SLOT;
  localparam logic [ADDR_W-3:0] STAT_WORD = (ADDR_W-2)'(N_SLOT * N_REG);

  logic              in_chan, is_stat;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        reg_sel;
  logic [STAT_W-1:0] stat;
  logic [DATA_W-1:0] chan_rd [N_CH];

  assign slot    = addr_i[SLOT_W+3:4];
  assign reg_sel = addr_i[3:2];
  assign in_chan = (addr_i[ADDR_W-1:SLOT_W+4] == '0);
  assign is_stat = (addr_i[ADDR_W-1:2] == STAT_WORD);

  for (genvar c = 0; c < N_SLOT; c++) begin : g_slot
    if (c < N_CH) begin : g_ch
      logic              hit;
      logic [N_REG-1:0]  wr_c, pend;
      logic              boundary;
      ctrl_t             sh_ctrl, act_ctrl;
      logic [PRE_W-1:0]  sh_pre, act_pre;
      logic [PER_W-1:0]  sh_per, act_per, sh_duty, act_duty;

      assign hit  = wr_en_i && in_chan && (slot == SLOT_W'(c));
      assign wr_c = hit ? (N_REG'(1) << reg_sel) : '0;

      pwm_chan_regs #(.DATA_W(DATA_W)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_c), .wdata_i(wdata_i),
        .boundary_i(boundary),
        .sh_ctrl_o(sh_ctrl), .act_ctrl_o(act_ctrl),
        .sh_pre_o(sh_pre), .act_pre_o(act_pre),
        .sh_per_o(sh_per), .act_per_o(act_per),
        .sh_duty_o(sh_duty), .act_duty_o(act_duty),
        .pend_o(pend));

      pwm_chan_core u_core (
        .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(act_ctrl),
        .pre_i(act_pre), .per_i(act_per), .duty_i(act_duty),
        .pwm_o(pwm_o[c]), .boundary_o(boundary));

      assign stat[N_REG*c +: N_REG] = pend;

      always_comb begin
        unique case (reg_sel)
          REG_CTRL: chan_rd[c] = DATA_W'(sh_ctrl);
          REG_PRE:  chan_rd[c] = DATA_W'(sh_pre);
          REG_PER:  chan_rd[c] = DATA_W'(sh_per);
          default:  chan_rd[c] = DATA_W'(sh_duty);
        endcase
      end
    end else begin : g_rsv
      assign stat[N_REG*c +: N_REG] = '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_stat) rdata_o = DATA_W'(stat);
    else if (in_chan) begin
      for (int c = 0; c < N_CH; c++)
        if (slot == SLOT_W'(c)) rdata_o = chan_rd[c];
    end
  end
endmodule

// File: tb/sim_pwm_shadow_top.sv
module sim_pwm_shadow_top;
  logic        clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  pwm;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_shadow_top u0 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr),
                     .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm));

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(int a, int d);
    @(negedge clk); wr = 1'b1; addr = 7'(a); wdata = 32'(d);
    @(posedge clk); @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 7'(a); #1; d = rdata;
  endtask

  function automatic logic exp_out(int t, int p, int n, int d, int inv);
    int c = (t / (p + 1)) % (n + 1);
    return logic'((c < d) ? 1 : 0) ^ logic'(inv);
  endfunction

  // stops channel, stages values (autoload while stopped), enables; returns at cycle 0
  task automatic cfg_run(int c, int p, int n, int d, int inv);
    logic [31:0] s;
    wr_reg(c*16, 'hC); repeat (3) @(negedge clk);
    wr_reg(c*16+4, p); wr_reg(c*16+8, n); wr_reg(c*16+12, d);
    repeat (2) @(negedge clk);
    rd('h40, s);
    chk("R5 stopped autoload copy", 32'((s >> (4*c)) & 'hF), 0);
    wr_reg(c*16, 5 | (inv << 1));
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic trial(int c, int p, int n, int d, int inv);
    int err = 0, oerr = 0, len;
    logic first_a = 0, first_e = 0;
    cfg_run(c, p, n, d, inv);
    len = 2 * (n + 1) * (p + 1);
    for (int t = 0; t < len; t++) begin
      if (pwm[c] !== exp_out(t, p, n, d, inv)) begin
        if (err == 0) begin first_a = pwm[c]; first_e = exp_out(t, p, n, d, inv); end
        err++;
      end
      if (pwm[1-c] !== 1'b0) oerr++;
      @(negedge clk);
    end
    chk("R7 R8 R9 waveform", 32'(first_a), 32'(first_e));
    chk("R12 idle channel", 32'(oerr), 0);
    wr_reg(c*16, 'hC);
  endtask

  task automatic win_count(int c, int n, output int cnt);
    cnt = 0;
    repeat (n) begin if (pwm[c]) cnt++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    int cnt;
    int masks [4] = '{'h3F, 'h3FF, 'hFFF, 'hFFF};
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", 32'(pwm), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 32; a += 4) begin rd(a, s); chk("R1 reg reset", s, 0); end
    rd('h40, s); chk("R1 status reset", s, 0);

    // R2 readback and R3 pending position
    for (int i = 0; i < 8; i++) begin
      int c = int'($urandom % 2), r = int'($urandom % 4);
      int v = int'($urandom);
      wr_reg(c*16 + r*4, v);
      rd('h40, s); chk("R3 pend bit", 32'((s >> (4*c + r)) & 1), 1);
      rd(c*16 + r*4, s); chk("R2 readback", s, 32'(v) & 32'(masks[r]));
    end
    wr_reg(0, 'hC); wr_reg(16, 'hC); repeat (3) @(negedge clk);
    rd('h40, s); chk("R5 stopped clears", s, 0);
    wr_reg('h20, 'hFFFF); rd('h20, s); chk("R2 unimpl read", s, 0);
    rd('h40, s); chk("R2 unimpl write no pend", s, 0);
    wr_reg('h40, 'hFFFF); rd('h40, s); chk("R2 status write ignored", s, 0);
    rd('h44, s); chk("R2 unmapped read", s, 0);

    // R4 control accept on ch1
    wr_reg(16, 0); rd('h40, s); chk("R3 ctrl pend ch1", s, 'h10);
    @(posedge clk); @(negedge clk); rd('h40, s); chk("R4 ctrl accepted", s, 0);

    // R6 manual loading on ch1 (autoload now clear)
    wr_reg(20, 5); repeat (5) @(negedge clk);
    rd('h40, s); chk("R6 pre held", s, 'h20);
    wr_reg(16, 'h10);
    @(posedge clk); @(negedge clk); rd('h40, s); chk("R6 pre still pend", s, 'h20);
    @(posedge clk); @(negedge clk); rd('h40, s); chk("R6 pre loaded", s, 0);
    wr_reg(24, 9); repeat (4) @(negedge clk);
    rd('h40, s); chk("R6 per held", s, 'h40);
    wr_reg(16, 'h20); repeat (2) @(posedge clk); @(negedge clk);
    rd('h40, s); chk("R6 per loaded", s, 0);
    wr_reg(28, 3); rd('h40, s); chk("R6 duty pend", s, 'h80);
    @(posedge clk); @(negedge clk); rd('h40, s); chk("R6 duty next edge", s, 0);
    wr_reg(16, 'hC); repeat (3) @(negedge clk);

    // R5 autoload at wrap on ch0
    cfg_run(0, 0, 7, 2, 0);
    win_count(0, 8, cnt); chk("R8 duty 2 window", 32'(cnt), 2);
    wr_reg(12, 5); rd('h40, s); chk("R5 duty pend running", 32'((s >> 3) & 1), 1);
    repeat (10) @(negedge clk);
    rd('h40, s); chk("R5 duty taken at wrap", 32'(s & 'hF), 0);
    win_count(0, 8, cnt); chk("R5 new duty window", 32'(cnt), 5);

    // R10 stop now
    cfg_run(0, 3, 9, 4095, 0);
    repeat (3) @(negedge clk);
    wr_reg(0, 'hC); chk("R10 high after write", 32'(pwm[0]), 1);
    @(posedge clk); @(negedge clk); chk("R10 high one edge", 32'(pwm[0]), 1);
    @(posedge clk); @(negedge clk); chk("R10 idle two edges", 32'(pwm[0]), 0);

    // R11 graceful stop, inverted idle (R12)
    cfg_run(0, 3, 9, 4095, 1);
    repeat (2) @(negedge clk);
    wr_reg(0, 'h6);
    repeat (20) @(negedge clk); chk("R11 still running", 32'(pwm[0]), 0);
    repeat (20) @(negedge clk); chk("R12 inverted idle", 32'(pwm[0]), 1);
    wr_reg(0, 'hC); repeat (3) @(negedge clk);

    // R8 edges
    trial(1, 1, 5, 0, 0);
    trial(0, 0, 5, 20, 1);
    for (int i = 0; i < 16; i++)
      trial(int'($urandom % 2), int'($urandom % 4), int'($urandom % 16),
            int'($urandom % 19), int'($urandom % 2));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule